// File: doc/BRIEF.md
# Spare-Word Repair Array

This block sits beside a small word-wide memory (16 words of 8 bits by default) and hides faulty words from the rest of the chip. It owns the memory's request port. While the chip runs its self-test it forwards the test engine's address, data and strobes to the memory. During that time it listens to the fault checker: every fault pulse carries the failing address and the value the word should hold. The block stores that pair in the next free spare word and marks it valid. If the address is already held, the stored value is refreshed and no further spare word is used.

Once the chip is back in normal operation, every external address is compared at once against all valid spare words. A write to a repaired address updates the spare word's data. The write also still goes to the memory. A read from a repaired address returns the spare data through an output multiplexer, in place of the memory word, with the same latency as the memory read. Only a fixed number of spare words exists. When a fault arrives on a new address after all of them are taken, a sticky overflow flag reports that the memory can no longer be fully repaired.

Top module: `spare_word_repair`

## Requirements
- R1: After reset no spare word is valid, `overflow` is 0, and every read returns the memory data unchanged.
- R2: With `test_mode`=1 the memory port carries `bist_addr`, `bist_wdata`, `bist_we` and `bist_re`. With `test_mode`=0 it carries `ext_addr`, `ext_wdata`, `ext_we` and `ext_re`.
- R3: A one-cycle `flt_pulse` in test mode stores `flt_addr` and `flt_data` in a spare word. A later normal-mode read of that address returns the stored `flt_data`.
- R4: Spare words are taken in order, lowest first. Up to SPARES (default 4) distinct faulty addresses are repaired without `overflow`.
- R5: A fault pulse on an address that a valid spare word already holds uses no new spare word. It replaces that word's data with the new `flt_data`.
- R6: A fault pulse on a new address when all spare words are taken sets `overflow` from the next clock edge. The flag stays set until reset, and the existing spare words keep their contents.
- R7: In normal mode a write (`ext_we`=1) to a repaired address replaces the spare data, and a later read of that address returns the written value.
- R8: In normal mode a read of an address held by no spare word returns `mem_rdata`.
- R9: With RD_LAT=1, a read issued with `ext_re` on clock edge N shows its result on `rd_data` after edge N+1, the same cycle as the memory's synchronous read data. Back-to-back reads that alternate between hit and miss each return their own value.
- R10: In normal mode `flt_pulse` has no effect: no spare word is programmed or changed.
- R11: In test mode `rd_data` equals `mem_rdata` even at a repaired address, so the checker sees the raw memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1: test-and-repair routing, 0: normal routing |
| flt_pulse | input | 1 | One-cycle fault indication from the checker |
| flt_addr | input | ADDR_W | Address of the failing word |
| flt_data | input | DATA_W | Correct (expected) data for the failing word |
| bist_addr | input | ADDR_W | Test engine address |
| bist_wdata | input | DATA_W | Test engine write data |
| bist_we | input | 1 | Test engine write strobe |
| bist_re | input | 1 | Test engine read strobe |
| ext_addr | input | ADDR_W | Functional address |
| ext_wdata | input | DATA_W | Functional write data |
| ext_we | input | 1 | Functional write strobe |
| ext_re | input | 1 | Functional read strobe |
| mem_rdata | input | DATA_W | Read data from the memory |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_wdata | output | DATA_W | Write data to the memory |
| mem_we | output | 1 | Write strobe to the memory |
| mem_re | output | 1 | Read strobe to the memory |
| rd_data | output | DATA_W | Read data after repair multiplexing |
| overflow | output | 1 | Sticky flag: more faulty addresses than spare words |

## Verification
The hardest case to reach from the ports is one where an ignored or duplicate fault pulse would silently consume a spare word. That error only shows later, as a different address failing to be repaired. The bench sends a fault pulse in normal mode and reads that address before any repair. It then fills the array with a repeated address in the middle of the sequence, so that one stolen slot would move the overflow point and change which of the later reads returns spare data. The memory model flips a bit at five addresses, so repaired and unrepaired reads give visibly different values.

// File: rtl/srw_pkg.sv
package srw_pkg;
   typedef enum logic {
      PATH_NORMAL = 1'b0,
      PATH_REPAIR = 1'b1
   } path_e;
endpackage

// File: rtl/srw_entry.sv
module srw_entry #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog,
   input  logic              upd,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [DATA_W-1:0] prog_data,
   input  logic [DATA_W-1:0] upd_data,
   input  logic [ADDR_W-1:0] flt_addr,
   input  logic [ADDR_W-1:0] look_addr,
   output logic              flt_hit,
   output logic              look_hit,
   output logic [DATA_W-1:0] data
);
   logic              valid;
   logic [ADDR_W-1:0] tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         tag   <= '0;
         data  <= '0;
      end else if (prog) begin
         valid <= 1'b1;
         tag   <= prog_addr;
         data  <= prog_data;
      end else if (upd) begin
         data  <= upd_data;
      end
   end

   assign flt_hit  = valid && (tag == flt_addr);
   assign look_hit = valid && (tag == look_addr);

   // R4: the allocator only ever programs a free spare word
   p_prog_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      prog |-> !valid);
endmodule

// File: rtl/srw_alloc.sv
module srw_alloc #(
   parameter int SPARES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              dup,
   output logic [SPARES-1:0] prog_oh,
   output logic              overflow
);
   localparam int CW = $clog2(SPARES + 1);

   logic [CW-1:0] fill;
   logic          full;
   logic          fresh;

   if (SPARES < 1) begin : g_bad_spares
      $error("srw_alloc: SPARES must be at least 1");
   end

   assign full  = (fill == CW'(SPARES));
   assign fresh = req && !dup;

   for (genvar i = 0; i < SPARES; i++) begin : g_sel
      assign prog_oh[i] = fresh && (fill == CW'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill     <= '0;
         overflow <= 1'b0;
      end else if (fresh) begin
         if (full) overflow <= 1'b1;
         else      fill     <= fill + CW'(1);
      end
   end

   // R6: overflow only once every spare word is taken
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> full);
   // R6: overflow is sticky
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   // R4: each new address advances the fill point by one
   p_fill_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh && !full) |=> (fill == $past(fill) + CW'(1)));
   // R5: a duplicate address consumes nothing
   p_dup_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && dup) |=> $stable(fill));
   // R4: at most one spare word programmed per cycle
   p_prog_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(prog_oh));
endmodule

// File: rtl/srw_rdmux.sv
module srw_rdmux #(
   parameter int DATA_W = 8,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [DATA_W-1:0] sel_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rd_data
);
   if (RD_LAT == 0) begin : g_comb
      assign rd_data = sel ? sel_data : mem_rdata;
   end else if (RD_LAT == 1) begin : g_reg
      logic              sel_q;
      logic [DATA_W-1:0] data_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q  <= 1'b0;
            data_q <= '0;
         end else begin
            sel_q  <= sel;
            if (sel) data_q <= sel_data;
         end
      end

      assign rd_data = sel_q ? data_q : mem_rdata;

      // R9: spare data of a hit appears one edge later, aligned to memory data
      p_hit_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
         sel |=> (rd_data == $past(sel_data)));
      // R8: a miss passes memory data in the following cycle
      p_miss_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !sel |=> (rd_data == mem_rdata));
   end else begin : g_bad_lat
      $error("srw_rdmux: RD_LAT must be 0 or 1");
   end
endmodule

// File: rtl/spare_word_repair.sv
module spare_word_repair
   import srw_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int SPARES = 4,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_mode,
   input  logic              flt_pulse,
   input  logic [ADDR_W-1:0] flt_addr,
   input  logic [DATA_W-1:0] flt_data,
   input  logic [ADDR_W-1:0] bist_addr,
   input  logic [DATA_W-1:0] bist_wdata,
   input  logic              bist_we,
   input  logic              bist_re,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic [DATA_W-1:0] ext_wdata,
   input  logic              ext_we,
   input  logic              ext_re,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   output logic [DATA_W-1:0] rd_data,
   output logic              overflow
);
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("spare_word_repair: widths must be positive");
   end
   if (SPARES > (1 << ADDR_W)) begin : g_bad_depth
      $error("spare_word_repair: more spare words than addresses");
   end

   path_e             path;
   logic              flt_req;
   logic              any_dup;
   logic              rd_sel;
   logic [SPARES-1:0] flt_hit_v;
   logic [SPARES-1:0] look_hit_v;
   logic [SPARES-1:0] prog_oh;
   logic [SPARES-1:0] upd_v;
   logic [DATA_W-1:0] upd_data;
   logic [DATA_W-1:0] hit_data;
   logic [DATA_W-1:0] sp_data [SPARES];

   assign path = test_mode ? PATH_REPAIR : PATH_NORMAL;

   always_comb begin
      if (path == PATH_REPAIR) begin
         mem_addr  = bist_addr;
         mem_wdata = bist_wdata;
         mem_we    = bist_we;
         mem_re    = bist_re;
      end else begin
         mem_addr  = ext_addr;
         mem_wdata = ext_wdata;
         mem_we    = ext_we;
         mem_re    = ext_re;
      end
   end

   assign flt_req  = (path == PATH_REPAIR) && flt_pulse;
   assign any_dup  = |flt_hit_v;
   assign upd_data = (path == PATH_REPAIR) ? flt_data : ext_wdata;

   srw_alloc #(.SPARES(SPARES)) u_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (flt_req),
      .dup      (any_dup),
      .prog_oh  (prog_oh),
      .overflow (overflow)
   );

   for (genvar i = 0; i < SPARES; i++) begin : g_spare
      assign upd_v[i] = (path == PATH_REPAIR) ? (flt_req && flt_hit_v[i])
                                              : (ext_we && look_hit_v[i]);
      srw_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entry (
         .clk       (clk),
         .rst_n     (rst_n),
         .prog      (prog_oh[i]),
         .upd       (upd_v[i]),
         .prog_addr (flt_addr),
         .prog_data (flt_data),
         .upd_data  (upd_data),
         .flt_addr  (flt_addr),
         .look_addr (ext_addr),
         .flt_hit   (flt_hit_v[i]),
         .look_hit  (look_hit_v[i]),
         .data      (sp_data[i])
      );
   end

   always_comb begin
      hit_data = '0;
      for (int i = 0; i < SPARES; i++) begin
         if (look_hit_v[i]) hit_data |= sp_data[i];
      end
   end

   assign rd_sel = (path == PATH_NORMAL) && ext_re && (|look_hit_v);

   srw_rdmux #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (rd_sel),
      .sel_data  (hit_data),
      .mem_rdata (mem_rdata),
      .rd_data   (rd_data)
   );

   // R5: no address is ever held by two spare words
   p_unique_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_hit_v) && $onehot0(flt_hit_v));
   // R10: fault pulses in normal mode program nothing
   p_ignore_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |-> (prog_oh == '0));
   // R11: in steady test mode the raw memory data is returned
   p_raw_test_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && $past(test_mode)) |-> (rd_data == mem_rdata));
endmodule

// File: tb/spare_word_repair_test.sv
module spare_word_repair_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       test_mode = 1'b0;
   logic       flt_pulse = 1'b0;
   logic [3:0] flt_addr = '0;
   logic [7:0] flt_data = '0;
   logic [3:0] bist_addr = '0;
   logic [7:0] bist_wdata = '0;
   logic       bist_we = 1'b0;
   logic       bist_re = 1'b0;
   logic [3:0] ext_addr = '0;
   logic [7:0] ext_wdata = '0;
   logic       ext_we = 1'b0;
   logic       ext_re = 1'b0;
   logic [7:0] mem_rdata;
   logic [3:0] mem_addr;
   logic [7:0] mem_wdata;
   logic       mem_we;
   logic       mem_re;
   logic [7:0] rd_data;
   logic       overflow;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] sh [16];
   logic [7:0] mem_arr [16];
   logic       re_d = 1'b0;

   always #5 clk = ~clk;

   spare_word_repair uut (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
      .flt_pulse(flt_pulse), .flt_addr(flt_addr), .flt_data(flt_data),
      .bist_addr(bist_addr), .bist_wdata(bist_wdata), .bist_we(bist_we), .bist_re(bist_re),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_we(ext_we), .ext_re(ext_re),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_re(mem_re), .rd_data(rd_data), .overflow(overflow)
   );

   // faulty memory model: five addresses return bit 4 inverted
   function automatic logic [7:0] flip(input logic [3:0] a);
      return (a == 4'd3 || a == 4'd7 || a == 4'd9 || a == 4'd12 || a == 4'd14) ? 8'h10 : 8'h00;
   endfunction

   function automatic logic [7:0] mexp(input logic [3:0] a);
      return sh[a] ^ flip(a);
   endfunction

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem_arr[i] = 8'h00;
         sh[i]      = 8'h00;
      end
      mem_rdata = 8'h00;
   end

   always @(posedge clk) begin
      if (mem_we) mem_arr[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem_arr[mem_addr] ^ flip(mem_addr);
      re_d <= mem_re;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (re_d) begin
            n_tests++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL R9: actual read result %0h expected no read", rd_data);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (rd_data !== e) begin
                  n_fail++;
                  $display("FAIL %s: actual %0h expected %0h", t, rd_data, e);
               end
            end
         end
      end
   end

   task automatic n_write(input logic [3:0] a, input logic [7:0] d);
      ext_addr = a; ext_wdata = d; ext_we = 1'b1;
      @(negedge clk);
      ext_we = 1'b0;
      sh[a] = d;
   endtask

   task automatic n_read(input logic [3:0] a, input logic [7:0] e, input string t);
      ext_addr = a; ext_re = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      ext_re = 1'b0;
   endtask

   task automatic b_write(input logic [3:0] a, input logic [7:0] d);
      bist_addr = a; bist_wdata = d; bist_we = 1'b1;
      @(negedge clk);
      bist_we = 1'b0;
      sh[a] = d;
   endtask

   task automatic b_read(input logic [3:0] a, input logic [7:0] e, input string t);
      bist_addr = a; bist_re = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      bist_re = 1'b0;
   endtask

   task automatic pulse(input logic [3:0] a, input logic [7:0] d);
      flt_addr = a; flt_data = d; flt_pulse = 1'b1;
      @(negedge clk);
      flt_pulse = 1'b0;
   endtask

   task automatic drain();
      repeat (2) @(negedge clk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 overflow after reset", int'(overflow), 0);

      for (int a = 0; a < 16; a++) n_write(4'(a), 8'hA5 ^ 8'(a));
      for (int a = 0; a < 16; a++) n_read(4'(a), mexp(4'(a)), "R1 R8 unrepaired read");
      drain();

      // R10: pulse in normal mode must not repair address 5
      pulse(4'd5, 8'h99);
      n_read(4'd5, mexp(4'd5), "R10 ignored pulse");
      drain();

      // R2: routing of the memory port
      test_mode = 1'b1; bist_addr = 4'd6; ext_addr = 4'd2;
      #1 chk("R2 test routing", int'(mem_addr), 6);
      test_mode = 1'b0;
      #1 chk("R2 normal routing", int'(mem_addr), 2);
      @(negedge clk);
      test_mode = 1'b1;
      @(negedge clk);
      b_write(4'd5, 8'h3C);
      b_read(4'd5, 8'h3C, "R2 test path read");
      drain();

      // fill: 3, 7, 3 again, 9, 12 -> four slots; 14 overflows
      pulse(4'd3, 8'h11);
      pulse(4'd7, 8'h22);
      pulse(4'd3, 8'h33);
      pulse(4'd9, 8'h44);
      pulse(4'd12, 8'h55);
      chk("R4 no overflow with four entries", int'(overflow), 0);
      pulse(4'd14, 8'h66);
      chk("R6 overflow on fifth address", int'(overflow), 1);
      b_read(4'd3, mexp(4'd3), "R11 raw memory in test mode");
      drain();

      test_mode = 1'b0;
      @(negedge clk);
      n_read(4'd3, 8'h33, "R5 refreshed duplicate");
      n_read(4'd7, 8'h22, "R3 repaired read");
      n_read(4'd9, 8'h44, "R4 third entry");
      n_read(4'd12, 8'h55, "R4 fourth entry");
      n_read(4'd14, mexp(4'd14), "R6 overflowed address unrepaired");
      n_read(4'd5, mexp(4'd5), "R8 miss read");
      drain();
      chk("R6 overflow sticky", int'(overflow), 1);

      n_write(4'd7, 8'hE1);
      n_read(4'd7, 8'hE1, "R7 write hit");
      n_write(4'd0, 8'h42);
      n_read(4'd0, mexp(4'd0), "R8 write miss");
      drain();

      // R9: back-to-back hit/miss reads
      n_read(4'd9, 8'h44, "R9 b2b hit");
      n_read(4'd0, mexp(4'd0), "R9 b2b miss");
      n_read(4'd12, 8'h55, "R9 b2b hit");
      n_read(4'd14, mexp(4'd14), "R9 b2b miss");
      n_read(4'd7, 8'hE1, "R9 b2b hit");
      drain();

      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 overflow cleared", int'(overflow), 0);
      n_read(4'd3, mexp(4'd3), "R1 entries cleared");
      n_read(4'd12, mexp(4'd12), "R1 entries cleared");
      drain();
      chk("R9 scoreboard empty", exp_q.size(), 0);

      summary();
      $finish;
   end
endmodule